// File: doc/BRIEF.md
# Interrupt Controller CPU Interface

This block sits between an interrupt distributor and one processor core. The distributor offers a single candidate interrupt, made of a valid flag, a 10-bit ID and an 8-bit priority. The block decides whether that candidate may interrupt the core and drives a level interrupt request. The core works through a small register bus. It reads a claim register to take the interrupt, which moves the interrupt from pending to active and pulses an acknowledge back to the distributor. It then writes a completion register to lower the running priority. In split mode it also writes a separate retire register to end the active state.

The block keeps a stack of the priorities of interrupts that have preempted one another. The running priority is the entry at the top of that stack, or 0xFF when nothing is running. A table of active slots holds every claimed interrupt until it is retired, so in split mode an interrupt can stay active after its priority has been dropped. A smaller number means a higher priority.

Top module: `irq_cpu_if`

Register map (word address on `busAddr`): 0 control (bit 0 enable, bit 1 split mode), 1 priority mask (bits 7:0), 2 claim (read only), 3 completion (write only, ID in bits 9:0), 4 retire (write only, ID in bits 9:0), 5 running priority (read only, bits 7:0). All other bits read as 0.

## Requirements
- R1: After reset the control register reads 0, the mask reads 0, the running priority reads 0xFF and `irqOut` is low.
- R2: The running priority register returns the priority of the most recently claimed interrupt whose priority has not been dropped, and 0xFF when there is none.
- R3: A claim read while `irqOut` is high returns the candidate ID in bits 9:0. In the same cycle it pulses `candAck` for one cycle, and the running priority becomes the candidate priority.
- R4: A claim read while `irqOut` is low returns 1023, leaves `candAck` low and changes no state.
- R5: `irqOut` is high only while enable is set, the candidate is valid with an ID below 1020, the priority stack is not full and an active slot is free, in addition to R10 and R11.
- R6: In legacy mode (control bit 1 = 0), a completion write of the ID at the top of the stack drops the running priority to the next stacked entry and frees that interrupt's active slot.
- R7: In split mode (control bit 1 = 1), a completion write of the top ID drops the running priority, but the interrupt keeps its active slot.
- R8: A completion write whose ID is 1020 or above, or differs from the ID at the top of the stack, has no effect.
- R9: A retire write frees the active slots of that ID only in split mode and only once that ID's priority has been dropped. Otherwise it has no effect.
- R10: A candidate signals only when its priority is strictly lower in value than the running priority.
- R11: A candidate signals only when its priority is strictly lower in value than the mask.
- R12: The control bits and the mask read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 3 | Register word address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the cycle of `busRd` |
| candValid | input | 1 | Distributor offers a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candPrio | input | 8 | Candidate priority, 0 is highest |
| candAck | output | 1 | One-cycle pulse when the candidate is claimed |
| irqOut | output | 1 | Level interrupt request to the core |

## Verification
Directed sequences cover the edge cases. A candidate whose priority equals the mask, or equals the running priority, separates strict from non-strict comparisons. A second claim of the same candidate separates one-shot claiming from repeated claiming. Completion writes with ID 0, and with an ID below the top of the stack, show whether the block compares against the stack top. In split mode, four interrupts are claimed and completed but not retired, and a fifth candidate stays blocked. This shows the difference between dropping priority and retiring, and shows that a retire write of an ID that was not dropped does nothing. A random phase mixes claims, matched and unmatched completions, retires, mask changes and mode changes against a bench model, which exercises nested preemption and stack unwinding.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ID_W-1:0]   SPURIOUS_ID   = 10'd1023;
  localparam logic [ID_W-1:0]   FIRST_RSVD_ID = 10'd1020;
  localparam logic [PRIO_W-1:0] IDLE_PRIO     = 8'hFF;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 3'd0,
    REG_MASK  = 3'd1,
    REG_CLAIM = 3'd2,
    REG_DONE  = 3'd3,
    REG_RET   = 3'd4,
    REG_RUN   = 3'd5
  } regSel_e;

  // at most one of push / pop / retire per cycle
  typedef struct packed {
    logic              push;
    logic              pop;
    logic              keepActive;
    logic              retire;
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } dpStrobe_t;
endpackage

// File: rtl/irq_dp.sv
module irq_dp
  import irq_cpu_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int ACT_SLOTS   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic [PRIO_W-1:0] runPrio,
  output logic [ID_W-1:0]   topId,
  output logic              stackEmpty,
  output logic              stackFull,
  output logic              slotFree
);
  localparam int SP_W   = $clog2(STACK_DEPTH + 1);
  localparam int IDX_W  = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int SLOT_W = (ACT_SLOTS > 1) ? $clog2(ACT_SLOTS) : 1;

  logic [ID_W-1:0]   stkId   [STACK_DEPTH];
  logic [PRIO_W-1:0] stkPrio [STACK_DEPTH];
  logic [SP_W-1:0]   sp;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  pushIdx;

  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(STACK_DEPTH));
  assign pushIdx    = IDX_W'(sp);
  assign topIdx     = IDX_W'(sp - SP_W'(1));
  assign topId      = stackEmpty ? SPURIOUS_ID : stkId[topIdx];
  assign runPrio    = stackEmpty ? IDLE_PRIO : stkPrio[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sp <= '0;
    end else if (strb.push && !stackFull) begin
      sp <= sp + SP_W'(1);
    end else if (strb.pop && !stackEmpty) begin
      sp <= sp - SP_W'(1);
    end
  end

  for (genvar s = 0; s < STACK_DEPTH; s++) begin : g_stk
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stkId[s]   <= '0;
        stkPrio[s] <= IDLE_PRIO;
      end else if (strb.push && !stackFull && pushIdx == IDX_W'(s)) begin
        stkId[s]   <= strb.id;
        stkPrio[s] <= strb.prio;
      end
    end
  end

  // active slot table
  logic [ACT_SLOTS-1:0] actValid;
  logic [ACT_SLOTS-1:0] actDropped;
  logic [ID_W-1:0]      actId [ACT_SLOTS];
  logic [ACT_SLOTS-1:0] doneHit;
  logic [ACT_SLOTS-1:0] retHit;
  logic [SLOT_W-1:0]    freeIdx;

  always_comb begin
    freeIdx = '0;
    for (int i = ACT_SLOTS - 1; i >= 0; i--) begin
      if (!actValid[i]) freeIdx = SLOT_W'(i);
    end
  end
  assign slotFree = !(&actValid);

  for (genvar a = 0; a < ACT_SLOTS; a++) begin : g_act
    assign doneHit[a] = actValid[a] && !actDropped[a] && (actId[a] == strb.id);
    assign retHit[a]  = actValid[a] && actDropped[a] && (actId[a] == strb.id);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        actValid[a]   <= 1'b0;
        actDropped[a] <= 1'b0;
        actId[a]      <= '0;
      end else if (strb.push && slotFree && freeIdx == SLOT_W'(a)) begin
        actValid[a]   <= 1'b1;
        actDropped[a] <= 1'b0;
        actId[a]      <= strb.id;
      end else if (strb.pop && doneHit[a]) begin
        if (strb.keepActive) actDropped[a] <= 1'b1;
        else                 actValid[a]   <= 1'b0;
      end else if (strb.retire && retHit[a]) begin
        actValid[a] <= 1'b0;
      end
    end
  end

  // claim only happens with room in both structures
  p_push_room_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (!stackFull && slotFree));
  // a claim sets the running priority to the claimed priority
  p_push_runprio_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (runPrio == $past(strb.prio)));
  // completion accepted only for the stack top
  p_pop_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (!stackEmpty && topId == strb.id));
  // dropping the last stacked entry returns to idle
  p_last_pop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && sp == SP_W'(1)) |=> (runPrio == IDLE_PRIO));
  p_one_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.push, strb.pop, strb.retire}) <= 1);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [PRIO_W-1:0] candPrio,
  output logic              candAck,
  output logic              irqOut,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic [ID_W-1:0]   topId,
  input  logic              stackEmpty,
  input  logic              stackFull,
  input  logic              slotFree,
  output dpStrobe_t         strb
);
  logic              ctrlEn;
  logic              ctrlSplit;
  logic [PRIO_W-1:0] maskReg;
  logic [ID_W-1:0]   wrId;
  logic              wrIdOk;
  logic              claimRd;
  logic              doneOk;
  logic              retireOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn    <= 1'b0;
      ctrlSplit <= 1'b0;
      maskReg   <= '0;
    end else if (busWr) begin
      if (busAddr == REG_CTRL) begin
        ctrlEn    <= busWrData[0];
        ctrlSplit <= busWrData[1];
      end
      if (busAddr == REG_MASK) maskReg <= busWrData[PRIO_W-1:0];
    end
  end

  assign irqOut = ctrlEn && candValid && (candId < FIRST_RSVD_ID)
               && (candPrio < maskReg) && (candPrio < runPrio)
               && !stackFull && slotFree;

  assign claimRd  = busRd && (busAddr == REG_CLAIM);
  assign candAck  = claimRd && irqOut;
  assign wrId     = busWrData[ID_W-1:0];
  assign wrIdOk   = (wrId < FIRST_RSVD_ID);
  assign doneOk   = busWr && (busAddr == REG_DONE) && wrIdOk && !stackEmpty && (topId == wrId);
  assign retireOk = busWr && (busAddr == REG_RET) && wrIdOk && ctrlSplit;

  always_comb begin
    strb            = '0;
    strb.push       = candAck;
    strb.pop        = doneOk && !candAck;
    strb.retire     = retireOk && !candAck && !doneOk;
    strb.keepActive = ctrlSplit;
    strb.id         = candAck ? candId : wrId;
    strb.prio       = candPrio;
  end

  always_comb begin
    busRdData = '0;
    if (busRd) begin
      unique case (busAddr)
        REG_CTRL:  busRdData = {{(DATA_W-2){1'b0}}, ctrlSplit, ctrlEn};
        REG_MASK:  busRdData = {{(DATA_W-PRIO_W){1'b0}}, maskReg};
        REG_CLAIM: busRdData = {{(DATA_W-ID_W){1'b0}}, irqOut ? candId : SPURIOUS_ID};
        REG_RUN:   busRdData = {{(DATA_W-PRIO_W){1'b0}}, runPrio};
        default:   busRdData = '0;
      endcase
    end
  end

  // a claimed candidate cannot signal again at its own priority
  p_claim_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    candAck |=> !(irqOut && candPrio == $past(candPrio)));
  // an unanswered claim leaves the running priority alone
  p_spurious_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    (claimRd && !irqOut) |=> $stable(runPrio));
  // signalling respects the running priority held by the datapath
  p_irq_below_run_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (candPrio < runPrio));
  p_ctrl_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == REG_CTRL) |=> (ctrlEn == $past(busWrData[0])));
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int ACT_SLOTS   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        candValid,
  input  logic [9:0]  candId,
  input  logic [7:0]  candPrio,
  output logic        candAck,
  output logic        irqOut
);
  dpStrobe_t         strb;
  logic [PRIO_W-1:0] runPrio;
  logic [ID_W-1:0]   topId;
  logic              stackEmpty;
  logic              stackFull;
  logic              slotFree;

  irq_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .candValid(candValid), .candId(candId), .candPrio(candPrio),
    .candAck(candAck), .irqOut(irqOut),
    .runPrio(runPrio), .topId(topId), .stackEmpty(stackEmpty),
    .stackFull(stackFull), .slotFree(slotFree), .strb(strb)
  );

  irq_dp #(.STACK_DEPTH(STACK_DEPTH), .ACT_SLOTS(ACT_SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .runPrio(runPrio), .topId(topId), .stackEmpty(stackEmpty),
    .stackFull(stackFull), .slotFree(slotFree)
  );
endmodule

// File: tb/irq_cpu_if_tb.sv
module irq_cpu_if_tb;
  localparam int DEPTH = 4;
  localparam int SLOTS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic cValid = 1'b0;
  logic [9:0] cId = '0;
  logic [7:0] cPrio = 8'hFF;
  logic candAck, irqOut;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_cpu_if #(.STACK_DEPTH(DEPTH), .ACT_SLOTS(SLOTS)) u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .candValid(cValid),
    .candId(cId), .candPrio(cPrio), .candAck(candAck), .irqOut(irqOut));

  // bench model
  bit mEn = 0, mSplit = 0;
  logic [7:0] mMask = 0;
  logic [9:0] mStkI [DEPTH];
  logic [7:0] mStkP [DEPTH];
  int mSp = 0;
  bit mAv [SLOTS];
  bit mAd [SLOTS];
  logic [9:0] mAi [SLOTS];

  function automatic logic [7:0] mRun();
    return (mSp == 0) ? 8'hFF : mStkP[mSp-1];
  endfunction

  function automatic bit mFree();
    for (int i = 0; i < SLOTS; i++) if (!mAv[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit mIrq();
    return mEn && cValid && (cId < 10'd1020) && (cPrio < mMask)
        && (cPrio < mRun()) && (mSp < DEPTH) && mFree();
  endfunction

  function automatic bit mIdle();
    for (int i = 0; i < SLOTS; i++) if (mAv[i]) return 1'b0;
    return (mSp == 0);
  endfunction

  function automatic bit mIsActive(logic [9:0] id);
    for (int i = 0; i < SLOTS; i++) if (mAv[i] && mAi[i] == id) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doRead(input logic [2:0] a, output logic [31:0] d,
                        output logic ak, output logic irqSeen);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #2;
    d = busRdData; ak = candAck; irqSeen = irqOut;
    @(posedge clk); #1;
    busRd = 1'b0;
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk); #1;
    busWr = 1'b0;
  endtask

  task automatic setCand(input bit v, input logic [9:0] id, input logic [7:0] p);
    @(negedge clk);
    cValid = v; cId = id; cPrio = p;
  endtask

  task automatic checkState(string req);
    logic [31:0] d; logic ak, iq;
    doRead(3'd5, d, ak, iq);
    check({req, " runprio"}, d, {24'b0, mRun()});
    check({req, " irq"}, {31'b0, iq}, {31'b0, mIrq()});
  endtask

  task automatic opClaim(string req);
    logic [31:0] d; logic ak, iq; bit exp;
    exp = mIrq();
    doRead(3'd2, d, ak, iq);
    check({req, " claim id"}, d, exp ? {22'b0, cId} : 32'd1023);
    check({req, " ack pulse"}, {31'b0, ak}, {31'b0, exp});
    if (exp) begin
      mStkI[mSp] = cId; mStkP[mSp] = cPrio; mSp++;
      for (int i = 0; i < SLOTS; i++)
        if (!mAv[i]) begin mAv[i] = 1; mAd[i] = 0; mAi[i] = cId; break; end
    end
  endtask

  task automatic opDone(input logic [9:0] id);
    doWrite(3'd3, {22'b0, id});
    if (id < 10'd1020 && mSp > 0 && mStkI[mSp-1] == id) begin
      mSp--;
      for (int i = 0; i < SLOTS; i++)
        if (mAv[i] && !mAd[i] && mAi[i] == id) begin
          if (mSplit) mAd[i] = 1; else mAv[i] = 0;
        end
    end
  endtask

  task automatic opRetire(input logic [9:0] id);
    doWrite(3'd4, {22'b0, id});
    if (mSplit && id < 10'd1020)
      for (int i = 0; i < SLOTS; i++)
        if (mAv[i] && mAd[i] && mAi[i] == id) mAv[i] = 0;
  endtask

  task automatic opCtrl(input bit en, input bit split);
    doWrite(3'd0, {30'b0, split, en});
    mEn = en; mSplit = split;
  endtask

  task automatic opMask(input logic [7:0] m);
    doWrite(3'd1, {24'b0, m});
    mMask = m;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d; logic ak, iq;
    void'($urandom(32'd4242));
    for (int i = 0; i < SLOTS; i++) begin mAv[i] = 0; mAd[i] = 0; mAi[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    doRead(3'd0, d, ak, iq); check("R1 ctrl", d, 0);
    doRead(3'd1, d, ak, iq); check("R1 mask", d, 0);
    doRead(3'd5, d, ak, iq); check("R1 runprio", d, 32'hFF);
    check("R1 irq", {31'b0, iq}, 0);

    // R12 readback
    opCtrl(1, 0); opMask(8'hF0);
    doRead(3'd0, d, ak, iq); check("R12 ctrl", d, 32'd1);
    doRead(3'd1, d, ak, iq); check("R12 mask", d, 32'hF0);

    // R11 mask strictness, R5 gating
    setCand(1, 10'd5, 8'hF0); checkState("R11 equal mask");
    setCand(1, 10'd5, 8'hEF); checkState("R11 below mask");
    setCand(1, 10'd1021, 8'h10); checkState("R5 reserved id");
    opCtrl(0, 0); setCand(1, 10'd5, 8'h80); checkState("R5 disabled");
    opCtrl(1, 0);

    // R3 claim, R4 second claim
    opClaim("R3");
    checkState("R3 after claim");
    opClaim("R4 repeat");
    checkState("R4 no change");

    // R10 equal priority cannot preempt, lower can
    setCand(1, 10'd7, 8'h80); checkState("R10 equal run");
    setCand(1, 10'd7, 8'h40); checkState("R10 preempt");
    opClaim("R10 nested");
    setCand(0, 10'd0, 8'hFF);
    checkState("R2 nested run");

    // R8 bad completions
    opDone(10'd0); checkState("R8 id zero");
    opDone(10'd5); checkState("R8 not top");
    opDone(10'd1023); checkState("R8 reserved");
    // R6 legacy unwinding
    opDone(10'd7); checkState("R6 restore");
    opDone(10'd5); checkState("R6 idle");

    // R7 split: drop without retiring exhausts slots
    opCtrl(1, 1);
    for (int k = 0; k < SLOTS; k++) begin
      setCand(1, 10'(10 + k), 8'h20);
      opClaim("R7 claim");
      opDone(10'(10 + k));
      checkState("R7 dropped");
    end
    setCand(1, 10'd14, 8'h20); checkState("R7 slots held");
    opRetire(10'd99); checkState("R9 unknown id");
    opRetire(10'd12); checkState("R9 retire frees");
    opClaim("R9 claim after retire");
    opRetire(10'd14); checkState("R9 retire before drop");
    opDone(10'd14); opRetire(10'd14);
    opRetire(10'd10); opRetire(10'd11); opRetire(10'd13);
    checkState("R9 all retired");
    opCtrl(1, 0);
    setCand(1, 10'd20, 8'h30); opClaim("R6 legacy claim");
    opDone(10'd20);
    opRetire(10'd20); checkState("R9 legacy retire ignored");

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int r;
      logic [9:0] nid;
      nid = 10'($urandom % 1024);
      setCand(($urandom % 5) != 0 && !mIsActive(nid), nid, 8'(($urandom % 8) * 32));
      r = $urandom % 10;
      if (r < 4) opClaim("R3 random");
      else if (r < 6) opDone(mSp > 0 ? mStkI[mSp-1] : nid);
      else if (r == 6) opDone(10'($urandom % 1024));
      else if (r == 7) begin
        logic [9:0] rid;
        rid = nid;
        for (int i = 0; i < SLOTS; i++) if (mAv[i] && mAd[i]) rid = mAi[i];
        opRetire(rid);
      end else if (r == 8) begin
        case ($urandom % 4)
          0: opMask(8'h40); 1: opMask(8'h80); 2: opMask(8'hF0); default: opMask(8'hFF);
        endcase
      end else if (mIdle()) opCtrl(1, 1'($urandom % 2));
      checkState("R2 random");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule